// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This block runs the SHA-1 compression function on one 512-bit message block and keeps the resulting 160-bit hash state as a chained digest. The host pads the message and encodes its length. It then hands the engine one block at a time.

The first block of a message is started with an init pulse. Init resets the chaining state to the standard starting words before the block is hashed. Each later block is started with a next pulse, which continues from whatever digest the previous block left behind.

The engine is iterative. A command costs one cycle to copy the chaining state into the working variables and capture the block. The engine then spends eighty cycles on the rounds, one round per cycle, and one more cycle adding the working variables back into the hash state. The sixteen-word message schedule is a sliding window that shifts once per round, so the schedule never stores all eighty words.

Top module: `sha1_engine`

## Requirements
- R1: After reset, `ready_o` is 1, `digest_valid_o` is 0 and `digest_o` holds the starting state 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0 (hex), with the first word in bits [159:128].
- R2: An init command hashes `block_i` starting from the standard starting state. Message word 0 is `block_i[511:480]` and word 15 is `block_i[31:0]`. The block is captured on the clock edge that accepts the command, so later changes to `block_i` have no effect.
- R3: A next command hashes `block_i` starting from the current value of `digest_o`. This lets a multi-block message be chained one block at a time.
- R4: Count the clock edge that accepts a command as edge 1. `digest_valid_o` and `ready_o` are both 0 after edge 81 and both 1 after edge 82.
- R5: From the edge that accepts a command until completion, `ready_o` and `digest_valid_o` are both 0.
- R6: An init or next pulse that arrives while `ready_o` is 0 is ignored. The digest of the block in progress is unaffected.
- R7: If init and next are asserted in the same cycle, init takes priority.
- R8: Each round uses the right f-function and constant for its quarter: Ch with 5A827999 for rounds 0-19, Parity with 6ED9EBA1 for rounds 20-39, Maj with 8F1BBCDC for rounds 40-59, and Parity with CA62C1D6 for rounds 60-79. The result matches the standard SHA-1 compression on every block.
- R9: `digest_o` does not change during the round cycles. It changes only on the edge that accepts an init command and on the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start a new hash with this block |
| next_i | input | 1 | Hash this block chained from the current digest |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| ready_o | output | 1 | Engine is idle and will accept a command |
| digest_o | output | 160 | Chained hash state, first word in the top 32 bits |
| digest_valid_o | output | 1 | Digest holds the result of the last accepted block |

## Verification
The bench checks the latency edge by edge. A finalize step that lands one cycle early or late moves `digest_valid_o` across the sampled edges. The bench also changes `block_i` right after acceptance and fires a stray init in the middle of a run. A design that re-reads the block, or that restarts on a busy command, then returns a digest that differs from the model.

The bench starts a run with init and next asserted together after a chained block. This exposes a design that gives next priority, because it would hash from the old digest. A known-answer block, a two-block chain and a series of random blocks drive every round quarter. A wrong f-function, a wrong constant or a wrong schedule tap therefore corrupts every digest.

// File: rtl/sha1_pkg.sv
package sha1_pkg;

    localparam int WORD_W  = 32;
    localparam int WIN_LEN = 16;
    localparam int BLOCK_W = WORD_W * WIN_LEN;
    localparam int ROUNDS  = 80;
    localparam int RND_W   = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } wv_t;

    localparam int STATE_W = $bits(wv_t);

    localparam wv_t START_STATE = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUND,
        ST_FINAL
    } st_t;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t mix_f(input rnd_t r, input word_t b, input word_t c,
                                    input word_t d);
        if (r < RND_W'(20))
            return (b & c) | (~b & d);
        else if (r < RND_W'(40))
            return b ^ c ^ d;
        else if (r < RND_W'(60))
            return (b & c) | (b & d) | (c & d);
        else
            return b ^ c ^ d;
    endfunction

    function automatic word_t round_k(input rnd_t r);
        if (r < RND_W'(20))
            return 32'h5A827999;
        else if (r < RND_W'(40))
            return 32'h6ED9EBA1;
        else if (r < RND_W'(60))
            return 32'h8F1BBCDC;
        else
            return 32'hCA62C1D6;
    endfunction

    function automatic wv_t round_step(input wv_t v, input word_t w, input rnd_t r);
        wv_t   n;
        word_t t;
        t   = rotl(v.a, 5) + mix_f(r, v.b, v.c, v.d) + v.e + round_k(r) + w;
        n.e = v.d;
        n.d = v.c;
        n.c = rotl(v.b, 30);
        n.b = v.a;
        n.a = t;
        return n;
    endfunction

    function automatic wv_t add_state(input wv_t h, input wv_t v);
        wv_t s;
        s.a = h.a + v.a;
        s.b = h.b + v.b;
        s.c = h.c + v.c;
        s.d = h.d + v.d;
        s.e = h.e + v.e;
        return s;
    endfunction

endpackage

// File: rtl/sha1_wsched.sv
module sha1_wsched
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  logic [BLOCK_W-1:0] block_i,
    output word_t              w_cur
);

    word_t win [WIN_LEN];
    word_t w_new;

    // New word for the far end of the window: taps at offsets 0, 2, 8 and 13.
    assign w_new = rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
    assign w_cur = win[0];

    for (genvar i = 0; i < WIN_LEN; i++) begin : g_win
        if (i == WIN_LEN - 1) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)
                    win[i] <= '0;
                else if (load)
                    win[i] <= block_i[(WIN_LEN-1-i)*WORD_W +: WORD_W];
                else if (shift)
                    win[i] <= w_new;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    win[i] <= '0;
                else if (load)
                    win[i] <= block_i[(WIN_LEN-1-i)*WORD_W +: WORD_W];
                else if (shift)
                    win[i] <= win[i+1];
            end
        end
    end

    // R2: the word presented first after a load is the top word of the block
    a_r2_first_word: assert property (@(posedge clk) disable iff (rst)
        load |=> (w_cur == $past(block_i[BLOCK_W-1 -: WORD_W])));

endmodule

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
    import sha1_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  logic next_i,
    output logic accept,
    output logic use_start,
    output logic step,
    output logic fin,
    output rnd_t rnd,
    output logic ready
);

    st_t  st_q;
    rnd_t rnd_q;

    assign ready     = (st_q == ST_IDLE);
    assign accept    = ready && (init_i || next_i);
    assign use_start = init_i;
    assign step      = (st_q == ST_ROUND);
    assign fin       = (st_q == ST_FINAL);
    assign rnd       = rnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            rnd_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    st_q  <= ST_ROUND;
                    rnd_q <= '0;
                end
                ST_ROUND: begin
                    if (rnd_q == RND_W'(ROUNDS - 1))
                        st_q <= ST_FINAL;
                    else
                        rnd_q <= rnd_q + 1'b1;
                end
                ST_FINAL: st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // R8: the round index never leaves the eighty-round range
    a_r8_round_range: assert property (@(posedge clk) disable iff (rst)
        step |-> (rnd_q < RND_W'(ROUNDS)));

    // R4: the finalize cycle always follows the last round
    a_r4_final_after_last: assert property (@(posedge clk) disable iff (rst)
        fin |-> ($past(step) && $past(rnd_q) == RND_W'(ROUNDS - 1)));

endmodule

// File: rtl/sha1_state.sv
module sha1_state
    import sha1_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  use_start,
    input  logic  step,
    input  logic  fin,
    input  rnd_t  rnd,
    input  word_t w_cur,
    output wv_t   h_q,
    output logic  valid_q
);

    wv_t v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q     <= START_STATE;
            v_q     <= '0;
            valid_q <= 1'b0;
        end else if (accept) begin
            valid_q <= 1'b0;
            if (use_start) begin
                h_q <= START_STATE;
                v_q <= START_STATE;
            end else begin
                v_q <= h_q;
            end
        end else if (step) begin
            v_q <= round_step(v_q, w_cur, rnd);
        end else if (fin) begin
            h_q     <= add_state(h_q, v_q);
            valid_q <= 1'b1;
        end
    end

    // R1: the cycle after reset shows the starting state and no valid digest
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (h_q == START_STATE && !valid_q));

    // R9: the chaining state does not move while rounds are running
    a_r9_hold_in_rounds: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(h_q));

endmodule

// File: rtl/sha1_engine.sv
module sha1_engine
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init_i,
    input  logic               next_i,
    input  logic [BLOCK_W-1:0] block_i,
    output logic               ready_o,
    output logic [STATE_W-1:0] digest_o,
    output logic               digest_valid_o
);

    logic  accept, use_start, step, fin;
    rnd_t  rnd;
    word_t w_cur;
    wv_t   h_q;

    sha1_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .init_i    (init_i),
        .next_i    (next_i),
        .accept    (accept),
        .use_start (use_start),
        .step      (step),
        .fin       (fin),
        .rnd       (rnd),
        .ready     (ready_o)
    );

    sha1_wsched u_wsched (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .shift   (step),
        .block_i (block_i),
        .w_cur   (w_cur)
    );

    sha1_state u_state (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .use_start (use_start),
        .step      (step),
        .fin       (fin),
        .rnd       (rnd),
        .w_cur     (w_cur),
        .h_q       (h_q),
        .valid_q   (digest_valid_o)
    );

    assign digest_o = h_q;

    // R5: an accepted command drops both ready and valid on the next cycle
    a_r5_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
        (ready_o && (init_i || next_i)) |=> (!ready_o && !digest_valid_o));

    // R4: valid only rises together with ready
    a_r4_valid_with_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(digest_valid_o) |-> ready_o);

    // R9: while busy, the digest changes only on the edge that ends the run
    a_r9_digest_hold: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> (ready_o || $stable(digest_o)));

    // R6: a command during a run never restarts it
    a_r6_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && (init_i || next_i) && !fin) |=> !ready_o);

endmodule

// File: tb/tb_sha1_engine.sv
`timescale 1ns/1ps
module tb_sha1_engine;

    logic         clk = 1'b0;
    logic         rst;
    logic         init_i;
    logic         next_i;
    logic [511:0] block_i;
    logic         ready_o;
    logic [159:0] digest_o;
    logic         digest_valid_o;

    localparam logic [159:0] IV_REF =
        160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    int unsigned n_total = 0;
    int unsigned n_pass  = 0;
    bit          finished = 1'b0;
    logic [159:0] model_h;

    always #2.5 clk = ~clk;

    sha1_engine dut (
        .clk            (clk),
        .rst            (rst),
        .init_i         (init_i),
        .next_i         (next_i),
        .block_i        (block_i),
        .ready_o        (ready_o),
        .digest_o       (digest_o),
        .digest_valid_o (digest_valid_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_compress(input logic [159:0] h,
                                                  input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [159:0] act, input logic [159:0] exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    // Runs one block. inject > 0 fires a stray init just before edge 'inject'.
    task automatic run_block(input bit ini, input bit nxt, input logic [511:0] blk,
                             input int inject, input string tag);
        logic [159:0] base, exp, held;
        base = ini ? IV_REF : model_h;
        exp  = ref_compress(base, blk);
        @(negedge clk);
        init_i = ini; next_i = nxt; block_i = blk;
        @(negedge clk);                       // edge 1 accepted the command
        init_i = 1'b0; next_i = 1'b0; block_i = rand_block();  // R2: block already captured
        chk(!ready_o && !digest_valid_o, {tag, " R5 busy after command"},
            {158'd0, ready_o, digest_valid_o}, 160'd0);
        held = digest_o;
        chk(held == base, {tag, " R9 digest at start of run"}, held, base);
        for (int c = 2; c <= 81; c++) begin
            if (c == inject) begin
                init_i = 1'b1; block_i = rand_block();   // R6 stray command
            end
            @(negedge clk);
            init_i = 1'b0;
            if (c == 41)
                chk(digest_o == held, {tag, " R9 digest stable mid run"}, digest_o, held);
        end
        chk(!digest_valid_o && !ready_o, {tag, " R4 not done after edge 81"},
            {158'd0, ready_o, digest_valid_o}, 160'd0);
        chk(digest_o == held, {tag, " R9 digest stable at edge 81"}, digest_o, held);
        @(negedge clk);                       // edge 82
        chk(digest_valid_o && ready_o, {tag, " R4 done after edge 82"},
            {158'd0, ready_o, digest_valid_o}, 160'd3);
        chk(digest_o == exp, {tag, " digest"}, digest_o, exp);
        model_h = exp;
    endtask

    initial begin
        logic [511:0] abc;
        void'($urandom(32'd20240611));
        rst = 1'b1; init_i = 1'b0; next_i = 1'b0; block_i = '0;
        model_h = IV_REF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ready_o == 1'b1, "R1 ready after reset", {159'd0, ready_o}, 160'd1);
        chk(digest_valid_o == 1'b0, "R1 valid after reset", {159'd0, digest_valid_o}, 160'd0);
        chk(digest_o == IV_REF, "R1 digest after reset", digest_o, IV_REF);

        // R2 / R8 known answer: single padded block of "abc"
        abc = '0;
        abc[511:480] = 32'h61626380;
        abc[31:0]    = 32'h00000018;
        run_block(1'b1, 1'b0, abc, 0, "R2 R8 known answer");
        chk(digest_o == 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D,
            "R8 known answer constant", digest_o,
            160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

        // R3 chaining with next
        run_block(1'b0, 1'b1, rand_block(), 0, "R3 chained next");

        // R6 stray init mid run is ignored
        run_block(1'b0, 1'b1, rand_block(), 30, "R6 busy init ignored");
        run_block(1'b0, 1'b1, rand_block(), 81, "R6 busy init at last round");

        // R7 init and next together: init wins
        run_block(1'b1, 1'b1, rand_block(), 0, "R7 init priority");

        // R8 random blocks, mixed init/next
        for (int i = 0; i < 8; i++) begin
            bit pick_init;
            pick_init = ($urandom % 3) == 0;
            run_block(pick_init, !pick_init, rand_block(), 0, "R8 random block");
        end

        // R3 next directly after reset chains from the starting state
        rst = 1'b1; @(negedge clk); rst = 1'b0; model_h = IV_REF;
        run_block(1'b0, 1'b1, abc, 0, "R3 next after reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule